// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block keeps coherence for a small direct-mapped, write-back, write-allocate cache that sits on a shared snooping bus. Each line holds a tag, a data word and one of three coherence states: Invalid, Shared (memory and perhaps other caches also have a valid copy) or Modified (this cache has the only copy, and it is dirty). Processor loads and stores enter on one port, and the transactions that other caches place on the bus enter on a snoop port. The controller handles both sources in the same cycle.

For each processor access the controller either completes it at once from the array, or raises a bus request and stalls the processor until the bus grants it. A miss that displaces a dirty line first writes the victim back to memory. For each snooped transaction that hits a valid line it moves the line to its new state. When the line was Modified it also flushes the dirty word onto the bus. Bus arbitration, memory timing and an exclusive-clean state are outside this block.

An address is `{tag, index}` with one data word per line. Bus commands use a 2-bit code: 0 none, 1 read, 2 read-exclusive, 3 writeback. The snoop port uses the same codes, and only codes 1 and 2 have an effect.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid; while no processor request is present, bus_req_o is 0 (none) and cpu_done_o and cpu_stall_o are low.
- R2: A processor read to a line that is Invalid (or holds another tag) issues bus code 1 (read) at the request address; cpu_done_o rises in the grant cycle with cpu_rdata_o equal to bus_rdata_i, and the line becomes Shared.
- R3: A processor write miss issues bus code 2 (read-exclusive) and the line becomes Modified holding the written word; a later read or write of that address completes with no bus transaction.
- R4: A read that hits a Shared line completes in the cycle the request appears, with no bus transaction; a write that hits a Shared line issues code 2 and leaves the line Modified.
- R5: Reads and writes that hit a Modified line complete in the cycle the request appears with no bus transaction, and reads return the last written word.
- R6: A snooped read (code 1) that hits a Modified line asserts flush_o in the same cycle with flush_data_o equal to the dirty word and moves the line to Shared, so a following processor write issues code 2.
- R7: A snooped read-exclusive (code 2) that hits a Modified line flushes the dirty word in the same cycle and invalidates the line, so a following processor read issues code 1.
- R8: A snooped read-exclusive that hits a Shared line invalidates it without a flush; a snooped read that hits a Shared line changes nothing and produces no flush.
- R9: A snooped transaction whose tag differs from the stored tag, or that targets an Invalid line, produces no flush and no state change.
- R10: A miss whose victim line is Modified first issues code 3 (writeback) with the victim's address `{victim tag, index}` and its dirty word on bus_wdata_o; after that grant the fill request (code 1 or 2) for the new address follows.
- R11: When a snooped transaction and a processor request reach the same line in the same cycle, the snoop takes effect first and the processor request is judged against the resulting state.
- R12: While a bus request waits for bus_gnt_i, cpu_stall_o stays high and bus_req_o and bus_addr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until cpu_done_o |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | TAG_W+IDX_W | Request address `{tag, index}` |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_done_o |
| cpu_done_o | output | 1 | Request completes at this clock edge |
| cpu_stall_o | output | 1 | Request present but not yet complete |
| bus_req_o | output | 2 | Bus command: 0 none, 1 read, 2 read-exclusive, 3 writeback |
| bus_addr_o | output | TAG_W+IDX_W | Address of the requested transaction |
| bus_wdata_o | output | DATA_W | Victim data for a writeback |
| bus_gnt_i | input | 1 | Bus grants the pending request this cycle |
| bus_rdata_i | input | DATA_W | Fill data, valid with bus_gnt_i |
| snp_valid_i | input | 1 | Snooped transaction present |
| snp_cmd_i | input | 2 | Snooped command, 1 read, 2 read-exclusive |
| snp_addr_i | input | TAG_W+IDX_W | Snooped address |
| flush_o | output | 1 | Dirty word driven onto the bus for the snoop |
| flush_data_o | output | DATA_W | Flushed word |

## Verification
The bench builds the block with its defaults of four lines, a 4-bit tag and an 8-bit word. With only four index slots, two addresses that share an index and differ in tag are easy to pick. That brings dirty-victim writebacks, snoops that miss on tag alone and same-line races between the snoop and processor ports into a short directed run. The 6-bit address lets the bench's memory model cover every address, so each fill and each flushed or written-back word can be followed through memory and checked on a later miss.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_RDX  = 2'd2,
    BUS_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_WB   = 2'd1,
    P_FILL = 2'd2
  } proc_st_e;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor-side read
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output line_st_e          a_st_o,
  output logic [DATA_W-1:0] a_data_o,
  // snoop-side read
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [TAG_W-1:0]  b_tag_o,
  output line_st_e          b_st_o,
  output logic [DATA_W-1:0] b_data_o,
  // snoop state update
  input  logic              s_we_i,
  input  logic [IDX_W-1:0]  s_idx_i,
  input  line_st_e          s_st_i,
  // processor-side update, wins over snoop update
  input  logic              c_we_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  line_st_e          c_st_i,
  input  logic              c_data_we_i,
  input  logic [DATA_W-1:0] c_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [LINES];
  line_st_e          st_q   [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        st_q[i]   <= ST_I;
        data_q[i] <= '0;
      end
    end else begin
      if (s_we_i) st_q[s_idx_i] <= s_st_i;
      if (c_we_i) begin
        tag_q[c_idx_i] <= c_tag_i;
        st_q[c_idx_i]  <= c_st_i;
        if (c_data_we_i) data_q[c_idx_i] <= c_data_i;
      end
    end
  end

  assign a_tag_o  = tag_q[a_idx_i];
  assign a_st_o   = st_q[a_idx_i];
  assign a_data_o = data_q[a_idx_i];
  assign b_tag_o  = tag_q[b_idx_i];
  assign b_st_o   = st_q[b_idx_i];
  assign b_data_o = data_q[b_idx_i];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             snp_valid_i,
  input  bus_cmd_e         snp_cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  line_st_e         line_st_i,
  output logic             flush_o,
  output logic             upd_o,
  output line_st_e         next_st_o
);
  logic hit;

  assign hit = snp_valid_i && (line_st_i != ST_I) && (snp_tag_i == line_tag_i);

  always_comb begin
    next_st_o = line_st_i;
    flush_o   = 1'b0;
    if (hit) begin
      unique case (snp_cmd_i)
        BUS_RD: begin
          if (line_st_i == ST_M) begin
            flush_o   = 1'b1;
            next_st_o = ST_S;
          end
        end
        BUS_RDX: begin
          flush_o   = (line_st_i == ST_M);
          next_st_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  assign upd_o = (next_st_o != line_st_i);
endmodule

// File: rtl/msi_proc_ctrl.sv
module msi_proc_ctrl
  import msi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cpu_req_i,
  input  logic     cpu_we_i,
  input  logic     hit_i,       // tag match and post-snoop state valid
  input  line_st_e eff_st_i,    // post-snoop state of the indexed line
  input  logic     bus_gnt_i,
  output bus_cmd_e cmd_o,
  output logic     wb_sel_o,    // bus address from victim tag
  output logic     done_o,
  output logic     stall_o,
  output logic     rdata_bus_o, // read data from bus fill
  output logic     arr_we_o,
  output line_st_e arr_st_o,
  output logic     arr_data_we_o,
  output logic     arr_data_bus_o
);
  proc_st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= P_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d           = st_q;
    cmd_o          = BUS_NONE;
    wb_sel_o       = 1'b0;
    done_o         = 1'b0;
    rdata_bus_o    = 1'b0;
    arr_we_o       = 1'b0;
    arr_st_o       = ST_I;
    arr_data_we_o  = 1'b0;
    arr_data_bus_o = 1'b0;
    unique case (st_q)
      P_IDLE: begin
        if (cpu_req_i) begin
          if (hit_i && !cpu_we_i) begin
            done_o = 1'b1;
          end else if (hit_i && eff_st_i == ST_M) begin
            done_o        = 1'b1;
            arr_we_o      = 1'b1;
            arr_st_o      = ST_M;
            arr_data_we_o = 1'b1;
          end else if (hit_i) begin
            st_d = P_FILL;          // upgrade from Shared
          end else if (eff_st_i == ST_M) begin
            st_d = P_WB;            // dirty victim
          end else begin
            st_d = P_FILL;
          end
        end
      end
      P_WB: begin
        if (eff_st_i != ST_M) begin
          st_d = P_FILL;            // victim already flushed by a snoop
        end else begin
          cmd_o    = BUS_WB;
          wb_sel_o = 1'b1;
          if (bus_gnt_i) begin
            arr_we_o = 1'b1;
            arr_st_o = ST_I;
            st_d     = P_FILL;
          end
        end
      end
      P_FILL: begin
        cmd_o = cpu_we_i ? BUS_RDX : BUS_RD;
        if (bus_gnt_i) begin
          done_o         = 1'b1;
          rdata_bus_o    = !cpu_we_i;
          arr_we_o       = 1'b1;
          arr_st_o       = cpu_we_i ? ST_M : ST_S;
          arr_data_we_o  = 1'b1;
          arr_data_bus_o = !cpu_we_i;
          st_d           = P_IDLE;
        end
      end
      default: st_d = P_IDLE;
    endcase
  end

  assign stall_o = cpu_req_i && !done_o;
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cpu_req_i,
  input  logic                    cpu_we_i,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]       cpu_wdata_i,
  output logic [DATA_W-1:0]       cpu_rdata_o,
  output logic                    cpu_done_o,
  output logic                    cpu_stall_o,
  output logic [1:0]              bus_req_o,
  output logic [TAG_W+IDX_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  input  logic                    bus_gnt_i,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  input  logic                    snp_valid_i,
  input  logic [1:0]              snp_cmd_i,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr_i,
  output logic                    flush_o,
  output logic [DATA_W-1:0]       flush_data_o
);
  localparam int ADDR_W = TAG_W + IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st, snp_next, eff_st, arr_st;
  logic [DATA_W-1:0] a_data, b_data, c_data;
  logic              snp_upd, hit, wb_sel, rdata_bus;
  logic              arr_we, arr_data_we, arr_data_bus;
  bus_cmd_e          cmd;

  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .a_idx_i     (cpu_idx),
    .a_tag_o     (a_tag),
    .a_st_o      (a_st),
    .a_data_o    (a_data),
    .b_idx_i     (snp_idx),
    .b_tag_o     (b_tag),
    .b_st_o      (b_st),
    .b_data_o    (b_data),
    .s_we_i      (snp_upd),
    .s_idx_i     (snp_idx),
    .s_st_i      (snp_next),
    .c_we_i      (arr_we),
    .c_idx_i     (cpu_idx),
    .c_tag_i     (cpu_tag),
    .c_st_i      (arr_st),
    .c_data_we_i (arr_data_we),
    .c_data_i    (c_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_cmd_i   (bus_cmd_e'(snp_cmd_i)),
    .snp_tag_i   (snp_tag),
    .line_tag_i  (b_tag),
    .line_st_i   (b_st),
    .flush_o     (flush_o),
    .upd_o       (snp_upd),
    .next_st_o   (snp_next)
  );

  // snoop result is seen by the processor side in the same cycle
  assign eff_st = (snp_upd && snp_idx == cpu_idx) ? snp_next : a_st;
  assign hit    = (eff_st != ST_I) && (a_tag == cpu_tag);

  msi_proc_ctrl u_proc (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_req_i      (cpu_req_i),
    .cpu_we_i       (cpu_we_i),
    .hit_i          (hit),
    .eff_st_i       (eff_st),
    .bus_gnt_i      (bus_gnt_i),
    .cmd_o          (cmd),
    .wb_sel_o       (wb_sel),
    .done_o         (cpu_done_o),
    .stall_o        (cpu_stall_o),
    .rdata_bus_o    (rdata_bus),
    .arr_we_o       (arr_we),
    .arr_st_o       (arr_st),
    .arr_data_we_o  (arr_data_we),
    .arr_data_bus_o (arr_data_bus)
  );

  assign c_data       = arr_data_bus ? bus_rdata_i : cpu_wdata_i;
  assign cpu_rdata_o  = rdata_bus ? bus_rdata_i : a_data;
  assign bus_req_o    = cmd;
  assign bus_addr_o   = wb_sel ? {a_tag, cpu_idx} : cpu_addr_i;
  assign bus_wdata_o  = a_data;
  assign flush_data_o = b_data;
endmodule

// File: rtl/msi_ctrl_chk.sv
module msi_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_done_o,
  input logic              cpu_stall_o,
  input logic [1:0]        bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_gnt_i,
  input logic              snp_valid_i,
  input logic              flush_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> (bus_req_o == 2'd0 && !cpu_done_o)); // R1

  AST_DONE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> (cpu_req_i && !cpu_stall_o)); // R2

  AST_PEND_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o != 2'd0 && !bus_gnt_i) |-> cpu_stall_o); // R12

  AST_PEND_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snp_valid_i && $past(bus_req_o != 2'd0 && !bus_gnt_i))
      |-> (bus_req_o == $past(bus_req_o) && bus_addr_o == $past(bus_addr_o))); // R12

  AST_WB_FILL_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o == 2'd3 && bus_gnt_i) |=> (bus_req_o == 2'd1 || bus_req_o == 2'd2)); // R10

  AST_FLUSH_ON_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> snp_valid_i); // R9
endmodule

bind msi_cache_ctrl msi_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_done_o  (cpu_done_o),
  .cpu_stall_o (cpu_stall_o),
  .bus_req_o   (bus_req_o),
  .bus_addr_o  (bus_addr_o),
  .bus_gnt_i   (bus_gnt_i),
  .snp_valid_i (snp_valid_i),
  .flush_o     (flush_o)
);

// File: tb/sim_msi_cache_ctrl.sv
module sim_msi_cache_ctrl;
  localparam int IDX_W = 2;
  localparam int TAG_W = 4;
  localparam int DW    = 8;
  localparam int AW    = TAG_W + IDX_W;
  localparam int NA    = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_done, cpu_stall;
  logic [1:0] bus_req;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_gnt = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic flush;
  logic [DW-1:0] flush_data;

  always #10 clk = ~clk;

  msi_cache_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_done_o(cpu_done),
    .cpu_stall_o(cpu_stall), .bus_req_o(bus_req), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .flush_o(flush), .flush_data_o(flush_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mem   [NA];
  logic [DW-1:0] ref_v [NA];

  // expected event: kind 0 bus grant, 1 flush, 2 cpu done
  typedef struct packed {
    logic [1:0]    kind;
    logic [1:0]    code;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          chk_data;
  } ev_t;
  ev_t   exp_q[$];
  string tag_q[$];

  function automatic logic [AW-1:0] mk(int t, int i);
    logic [TAG_W-1:0] tt = t[TAG_W-1:0];
    logic [IDX_W-1:0] ii = i[IDX_W-1:0];
    return {tt, ii};
  endfunction

  task automatic check(bit ok, string r, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, expv);
    end
  endtask

  task automatic push(logic [1:0] kind, logic [1:0] code, logic [AW-1:0] a,
                      logic [DW-1:0] d, logic chk, string r);
    ev_t e;
    e.kind = kind; e.code = code; e.addr = a; e.data = d; e.chk_data = chk;
    exp_q.push_back(e);
    tag_q.push_back(r);
  endtask

  task automatic observe(logic [1:0] kind, logic [1:0] code, logic [AW-1:0] a,
                         logic [DW-1:0] d);
    ev_t e;
    string r;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", $sformatf("unexpected event kind %0d addr", kind), a, 0);
      return;
    end
    e = exp_q.pop_front();
    r = tag_q.pop_front();
    check(e.kind == kind, r, "event kind", kind, e.kind);
    check(e.code == code, r, "bus code", code, e.code);
    check(e.addr == a, r, "address", a, e.addr);
    if (e.chk_data) check(e.data == d, r, "data", d, e.data);
  endtask

  // monitor: samples away from both edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (bus_req != 2'd0 && bus_gnt) begin
          observe(2'd0, bus_req, bus_addr, bus_wdata);
          if (bus_req == 2'd3) mem[bus_addr] = bus_wdata;
        end
        if (flush) begin
          observe(2'd1, 2'd0, snp_addr, flush_data);
          mem[snp_addr] = flush_data;
        end
        if (cpu_done) observe(2'd2, 2'd0, cpu_addr, cpu_rdata);
      end
    end
  end

  // processor access; called at a negedge, returns at a negedge
  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] d, bit local_hit, string r);
    int cnt = 0;
    push(2'd2, 2'd0, a, ref_v[a], !we, r);
    if (we) ref_v[a] = d;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    check(cpu_done == local_hit, r, "done in request cycle", cpu_done, local_hit);
    check(cpu_stall == !local_hit, r, "stall in request cycle", cpu_stall, !local_hit);
    forever begin
      if (cpu_done) begin
        @(negedge clk);
        cpu_req = 1'b0; bus_gnt = 1'b0; snp_valid = 1'b0;
        break;
      end
      @(negedge clk);
      snp_valid = 1'b0;
      bus_gnt = 1'b0;
      if (bus_req != 2'd0) begin
        cnt++;
        if (cnt >= 2) begin
          bus_gnt = 1'b1;
          bus_rdata = mem[bus_addr];
          cnt = 0;
        end
      end
      #1;
    end
  endtask

  task automatic snoop_set(logic [1:0] cmd, logic [AW-1:0] a);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
  endtask

  task automatic snoop(logic [1:0] cmd, logic [AW-1:0] a);
    snoop_set(cmd, a);
    @(negedge clk);
    snp_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NA; i++) begin
      mem[i]   = DW'(i * 7 + 3);
      ref_v[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(bus_req == 2'd0, "R1", "bus_req after reset", bus_req, 0);
    check(!cpu_stall && !cpu_done, "R1", "stall/done after reset", {cpu_stall, cpu_done}, 0);
    check(!flush, "R1", "flush after reset", flush, 0);
    // R1: lines start invalid -> first read misses
    push(2'd0, 2'd1, mk(1, 0), '0, 1'b0, "R1");
    cpu_op(1'b0, mk(1, 0), '0, 1'b0, "R2");
    // R4: shared read hit
    cpu_op(1'b0, mk(1, 0), '0, 1'b1, "R4");
    // R4: shared write -> upgrade
    push(2'd0, 2'd2, mk(1, 0), '0, 1'b0, "R4");
    cpu_op(1'b1, mk(1, 0), 8'h5A, 1'b0, "R4");
    // R5: modified hits stay local
    cpu_op(1'b0, mk(1, 0), '0, 1'b1, "R5");
    cpu_op(1'b1, mk(1, 0), 8'h6B, 1'b1, "R5");
    // R6: snooped read on modified
    push(2'd1, 2'd0, mk(1, 0), ref_v[mk(1, 0)], 1'b1, "R6");
    snoop(2'd1, mk(1, 0));
    push(2'd0, 2'd2, mk(1, 0), '0, 1'b0, "R6");
    cpu_op(1'b1, mk(1, 0), 8'h7C, 1'b0, "R6");
    // R7: snooped read-exclusive on modified
    push(2'd1, 2'd0, mk(1, 0), ref_v[mk(1, 0)], 1'b1, "R7");
    snoop(2'd2, mk(1, 0));
    push(2'd0, 2'd1, mk(1, 0), '0, 1'b0, "R7");
    cpu_op(1'b0, mk(1, 0), '0, 1'b0, "R7");
    // R8: snooped read on shared leaves it; read-exclusive invalidates
    snoop(2'd1, mk(1, 0));
    cpu_op(1'b0, mk(1, 0), '0, 1'b1, "R8");
    snoop(2'd2, mk(1, 0));
    push(2'd0, 2'd1, mk(1, 0), '0, 1'b0, "R8");
    cpu_op(1'b0, mk(1, 0), '0, 1'b0, "R8");
    // R9: tag mismatch snoop ignored
    snoop(2'd2, mk(2, 0));
    cpu_op(1'b0, mk(1, 0), '0, 1'b1, "R9");
    // R3: write miss
    push(2'd0, 2'd2, mk(3, 1), '0, 1'b0, "R3");
    cpu_op(1'b1, mk(3, 1), 8'h91, 1'b0, "R3");
    snoop(2'd1, mk(4, 1));   // R9 mismatch on modified line
    snoop(2'd2, mk(0, 2));   // R9 invalid line
    cpu_op(1'b0, mk(3, 1), '0, 1'b1, "R3");
    // R10: dirty victim writeback then fill
    push(2'd0, 2'd3, mk(3, 1), 8'h91, 1'b1, "R10");
    push(2'd0, 2'd1, mk(5, 1), '0, 1'b0, "R10");
    cpu_op(1'b0, mk(5, 1), '0, 1'b0, "R10");
    push(2'd0, 2'd1, mk(3, 1), '0, 1'b0, "R10");
    cpu_op(1'b0, mk(3, 1), '0, 1'b0, "R10");
    // R11: same-cycle snoop read-exclusive and cpu read on modified line
    push(2'd0, 2'd2, mk(6, 3), '0, 1'b0, "R3");
    cpu_op(1'b1, mk(6, 3), 8'hD4, 1'b0, "R3");
    push(2'd1, 2'd0, mk(6, 3), ref_v[mk(6, 3)], 1'b1, "R11");
    push(2'd0, 2'd1, mk(6, 3), '0, 1'b0, "R11");
    snoop_set(2'd2, mk(6, 3));
    cpu_op(1'b0, mk(6, 3), '0, 1'b0, "R11");
    // R11: same-cycle snoop read and cpu write on modified line
    push(2'd0, 2'd2, mk(7, 2), '0, 1'b0, "R3");
    cpu_op(1'b1, mk(7, 2), 8'hE5, 1'b0, "R3");
    push(2'd1, 2'd0, mk(7, 2), ref_v[mk(7, 2)], 1'b1, "R11");
    push(2'd0, 2'd2, mk(7, 2), '0, 1'b0, "R11");
    snoop_set(2'd1, mk(7, 2));
    cpu_op(1'b1, mk(7, 2), 8'hF6, 1'b0, "R11");
    cpu_op(1'b0, mk(7, 2), '0, 1'b1, "R11");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12", "expected events left", exp_q.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule